// File: doc/BRIEF.md
# Token-Counting Coherence Controller

This block keeps coherence for one memory block on behalf of a single cache, using token counting instead of message ordering. A fixed pool of tokens exists for the block across the whole system. The controller holds some share of that pool, and its access right follows from that share alone. Any share gives read-only access. The whole pool gives read/write access. An empty share gives no access.

Peers ask for the block with read or write requests. The controller answers them by handing over tokens together with its copy of the data. When the local cache needs more rights than its share gives, the controller sends a request of its own. It waits for tokens to arrive and sends the request again each time a retry timer expires without the needed share. Races in the unordered network can leave tokens scattered across peers, and this retry loop is what gathers them back.

Top module: `tok_coherence_ctrl`

## Requirements
- R1: After a synchronous reset, the cache whose id equals HOME_ID holds all TOTAL_TOKENS (16) tokens. Every other cache holds 0. No outgoing message is valid and the error flag is low.
- R2: The `perm` output is 0 (none) when 0 tokens are held, 1 (read-only) for 1 to 15 tokens, and 2 (read/write) for all 16. A local read is granted with at least one token. A local write is granted only with all 16.
- R3: An incoming read request (kind 0) that arrives while all 16 tokens are held is answered on the next cycle. The answer is a token message (kind 2) to the requester carrying exactly 1 token and the block data. The controller keeps 15 tokens.
- R4: An incoming read request that arrives while fewer than 16 tokens are held gets no reply, and the held count does not change.
- R5: An incoming write request (kind 1) that arrives while a non-zero count is held is answered on the next cycle. The answer is a token message to the requester carrying every held token and the data. The held count drops to 0.
- R6: With 0 tokens held, incoming read and write requests are ignored: no message is sent.
- R7: A local access the current share cannot satisfy sends a request one cycle after it is accepted. The request has kind 0 for a read or 1 for a write, out_node equal to MY_ID, and out_reissue low. The grant pulse comes one cycle after the needed count is reached.
- R8: While unsatisfied, the request is sent again every TIMEOUT cycles with out_reissue high. Once the access is granted, no further requests are sent.
- R9: The tokens in an incoming token message are added to the held count. The message data is taken in only when the count was 0. A sum above 16 leaves the count unchanged and sets a sticky error flag.
- R10: If a reply to an incoming request and a timeout reissue fall in the same cycle, the reply is sent first and the reissue follows on the next cycle.
- R11: A granted local write stores loc_wdata as the block data. A granted read returns the block data on loc_rdata in the same cycle as the grant pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local access request, taken when loc_busy is low |
| loc_write | input | 1 | 1 = local write, 0 = local read |
| loc_wdata | input | DATA_W | Data for a local write |
| loc_busy | output | 1 | A local access is pending |
| loc_grant | output | 1 | One-cycle pulse: local access performed |
| loc_rdata | output | DATA_W | Block data at grant |
| in_valid | input | 1 | Incoming message valid |
| in_kind | input | 2 | 0 read request, 1 write request, 2 tokens |
| in_node | input | NODE_W | Requester id (requests) or sender id (tokens) |
| in_tokens | input | TOK_W | Token count carried |
| in_data | input | DATA_W | Block data carried |
| out_valid | output | 1 | Outgoing message valid |
| out_kind | output | 2 | 0 read request, 1 write request, 2 tokens |
| out_node | output | NODE_W | Own id for requests, destination for tokens |
| out_tokens | output | TOK_W | Tokens handed over |
| out_data | output | DATA_W | Block data handed over |
| out_reissue | output | 1 | Request is a timeout retry |
| tok_count | output | TOK_W | Tokens held |
| perm | output | 2 | Access permission |
| tok_err | output | 1 | Sticky token overflow flag |

## Verification
The outgoing port is shared by two functions: answering a peer's request and sending the local controller's own request or retry. These can collide when a peer's write request is sampled on the same edge at which the retry timer expires. The bench finds the issue edge of a pending write. It counts TIMEOUT cycles from that edge and lands an incoming write request exactly on the expiry edge. It then expects, in order, the token reply on the next cycle and the retry on the cycle after that. Retry spacing is also measured by counting cycles between consecutive requests.

// File: rtl/tok_pkg.sv
package tok_pkg;

  typedef enum logic [1:0] {
    K_RD_REQ = 2'd0,
    K_WR_REQ = 2'd1,
    K_TOKENS = 2'd2
  } msg_kind_e;

  typedef enum logic [1:0] {
    P_NONE  = 2'd0,
    P_READ  = 2'd1,
    P_WRITE = 2'd2
  } perm_e;

  function automatic perm_e perm_of(input int unsigned cnt, input int unsigned total);
    if (cnt == 0)          return P_NONE;
    else if (cnt >= total) return P_WRITE;
    else                   return P_READ;
  endfunction

endpackage

// File: rtl/tok_ledger.sv
module tok_ledger #(
  parameter int unsigned TOTAL_TOKENS = 16,
  parameter int unsigned TOK_W        = 5,
  parameter bit          START_FULL   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [TOK_W-1:0] add_amt,
  input  logic             give_one,
  input  logic             give_all,
  output logic [TOK_W-1:0] count,
  output logic [1:0]       perm,
  output logic             overflow,
  output logic             add_ok
);
  import tok_pkg::*;

  localparam logic [TOK_W-1:0] FULL = TOK_W'(TOTAL_TOKENS);
  localparam logic [TOK_W-1:0] INIT = START_FULL ? FULL : '0;

  logic [TOK_W:0]   sum;
  logic             sum_over;
  logic [TOK_W-1:0] nxt;

  assign sum      = {1'b0, count} + {1'b0, add_amt};
  assign sum_over = sum > {1'b0, FULL};
  assign add_ok   = add_en && !sum_over;

  always_comb begin
    nxt = count;
    if (add_en) begin
      if (!sum_over) nxt = sum[TOK_W-1:0];
    end else if (give_all) begin
      nxt = '0;
    end else if (give_one) begin
      nxt = count - TOK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= INIT;
      perm     <= perm_of(32'(INIT), TOTAL_TOKENS);
      overflow <= 1'b0;
    end else begin
      count <= nxt;
      perm  <= perm_of(32'(nxt), TOTAL_TOKENS);
      if (add_en && sum_over) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/tok_retry_timer.sv
module tok_retry_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run && !expired) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/tok_msg_port.sv
module tok_msg_port #(
  parameter int unsigned NODE_W = 2,
  parameter int unsigned TOK_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_reply,
  input  logic [NODE_W-1:0] reply_node,
  input  logic [TOK_W-1:0]  reply_tokens,
  input  logic [DATA_W-1:0] reply_data,
  input  logic              send_req,
  input  logic              req_write,
  input  logic              req_reissue,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [NODE_W-1:0] out_node,
  output logic [TOK_W-1:0]  out_tokens,
  output logic [DATA_W-1:0] out_data,
  output logic              out_reissue
);
  import tok_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_kind    <= K_RD_REQ;
      out_node    <= '0;
      out_tokens  <= '0;
      out_data    <= '0;
      out_reissue <= 1'b0;
    end else if (send_reply) begin
      out_valid   <= 1'b1;
      out_kind    <= K_TOKENS;
      out_node    <= reply_node;
      out_tokens  <= reply_tokens;
      out_data    <= reply_data;
      out_reissue <= 1'b0;
    end else if (send_req) begin
      out_valid   <= 1'b1;
      out_kind    <= req_write ? K_WR_REQ : K_RD_REQ;
      out_node    <= NODE_W'(MY_ID);
      out_tokens  <= '0;
      out_data    <= '0;
      out_reissue <= req_reissue;
    end else begin
      out_valid   <= 1'b0;
      out_reissue <= 1'b0;
    end
  end

endmodule

// File: rtl/tok_coherence_ctrl.sv
module tok_coherence_ctrl #(
  parameter int unsigned TOTAL_TOKENS = 16,
  parameter int unsigned NODE_W       = 2,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned MY_ID        = 0,
  parameter int unsigned HOME_ID      = 0,
  parameter int unsigned TIMEOUT      = 16,
  parameter int unsigned TOK_W        = $clog2(TOTAL_TOKENS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_valid,
  input  logic              loc_write,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic              loc_busy,
  output logic              loc_grant,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [NODE_W-1:0] in_node,
  input  logic [TOK_W-1:0]  in_tokens,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [NODE_W-1:0] out_node,
  output logic [TOK_W-1:0]  out_tokens,
  output logic [DATA_W-1:0] out_data,
  output logic              out_reissue,
  output logic [TOK_W-1:0]  tok_count,
  output logic [1:0]        perm,
  output logic              tok_err
);
  import tok_pkg::*;

  localparam logic [TOK_W-1:0] FULL = TOK_W'(TOTAL_TOKENS);
  localparam bit IS_HOME = (MY_ID == HOME_ID);

  // pending local access
  logic              want_valid, want_write, issue_due, sent_once;
  logic [DATA_W-1:0] want_data;
  logic [DATA_W-1:0] blk_data;

  logic accept, satisfied, grant_now;
  logic rd_reply, wr_reply, reply;
  logic want_issue, send_req, timer_run, timer_restart, expired;
  logic tok_in, add_ok;
  logic [TOK_W-1:0]  reply_tokens;
  logic [DATA_W-1:0] reply_data;

  assign accept    = loc_valid && !want_valid;
  assign satisfied = want_write ? (tok_count == FULL) : (tok_count != '0);
  assign grant_now = want_valid && satisfied;

  assign rd_reply = in_valid && (in_kind == K_RD_REQ) && (tok_count == FULL);
  assign wr_reply = in_valid && (in_kind == K_WR_REQ) && (tok_count != '0);
  assign reply    = rd_reply || wr_reply;
  assign tok_in   = in_valid && (in_kind == K_TOKENS);

  assign reply_tokens = wr_reply ? tok_count : TOK_W'(1);
  assign reply_data   = (grant_now && want_write) ? want_data : blk_data;

  assign want_issue    = want_valid && !satisfied && (issue_due || expired);
  assign send_req      = want_issue && !reply;
  assign timer_run     = want_valid && !satisfied && !issue_due;
  assign timer_restart = accept || grant_now || send_req;

  tok_ledger #(
    .TOTAL_TOKENS(TOTAL_TOKENS),
    .TOK_W       (TOK_W),
    .START_FULL  (IS_HOME)
  ) u_ledger (
    .clk     (clk),
    .rst     (rst),
    .add_en  (tok_in),
    .add_amt (in_tokens),
    .give_one(rd_reply),
    .give_all(wr_reply),
    .count   (tok_count),
    .perm    (perm),
    .overflow(tok_err),
    .add_ok  (add_ok)
  );

  tok_retry_timer #(
    .TIMEOUT(TIMEOUT)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(timer_restart),
    .run    (timer_run),
    .expired(expired)
  );

  tok_msg_port #(
    .NODE_W(NODE_W),
    .TOK_W (TOK_W),
    .DATA_W(DATA_W),
    .MY_ID (MY_ID)
  ) u_port (
    .clk         (clk),
    .rst         (rst),
    .send_reply  (reply),
    .reply_node  (in_node),
    .reply_tokens(reply_tokens),
    .reply_data  (reply_data),
    .send_req    (send_req),
    .req_write   (want_write),
    .req_reissue (sent_once),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_node    (out_node),
    .out_tokens  (out_tokens),
    .out_data    (out_data),
    .out_reissue (out_reissue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      want_valid <= 1'b0;
      want_write <= 1'b0;
      want_data  <= '0;
      issue_due  <= 1'b0;
      sent_once  <= 1'b0;
    end else if (grant_now) begin
      want_valid <= 1'b0;
      issue_due  <= 1'b0;
      sent_once  <= 1'b0;
    end else if (accept) begin
      want_valid <= 1'b1;
      want_write <= loc_write;
      want_data  <= loc_wdata;
      issue_due  <= 1'b1;
      sent_once  <= 1'b0;
    end else if (send_req) begin
      issue_due  <= 1'b0;
      sent_once  <= 1'b1;
    end else if (want_issue) begin
      issue_due  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_data  <= '0;
      loc_grant <= 1'b0;
      loc_rdata <= '0;
    end else begin
      loc_grant <= grant_now;
      if (grant_now) loc_rdata <= want_write ? want_data : blk_data;
      if (grant_now && want_write) blk_data <= want_data;
      else if (add_ok && tok_count == '0 && in_tokens != '0) blk_data <= in_data;
    end
  end

  assign loc_busy = want_valid;

endmodule

// File: rtl/tok_coherence_ctrl_chk.sv
module tok_coherence_ctrl_chk #(
  parameter int unsigned TOTAL_TOKENS = 16,
  parameter int unsigned TOK_W        = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_kind,
  input logic [TOK_W-1:0] in_tokens,
  input logic             out_valid,
  input logic [1:0]       out_kind,
  input logic [TOK_W-1:0] out_tokens,
  input logic             out_reissue,
  input logic             loc_busy,
  input logic             loc_grant,
  input logic [TOK_W-1:0] tok_count,
  input logic [1:0]       perm,
  input logic             tok_err
);
  localparam logic [TOK_W-1:0] FULL = TOK_W'(TOTAL_TOKENS);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    tok_count <= FULL);

  p_overflow_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd2 && ({1'b0, tok_count} + {1'b0, in_tokens}) > {1'b0, FULL})
    |=> (tok_err && tok_count == $past(tok_count)));

  p_read_one_token_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd0 && tok_count == FULL)
    |=> (out_valid && out_kind == 2'd2 && out_tokens == TOK_W'(1) && tok_count == FULL - TOK_W'(1)));

  p_partial_read_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd0 && tok_count != FULL)
    |=> !(out_valid && out_kind == 2'd2));

  p_write_all_tokens_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'd1 && tok_count != '0)
    |=> (out_valid && out_kind == 2'd2 && out_tokens == $past(tok_count) && tok_count == '0));

  p_zero_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind != 2'd2 && tok_count == '0)
    |=> !(out_valid && out_kind == 2'd2));

  p_perm_full_r2: assert property (@(posedge clk) disable iff (rst)
    (perm == 2'd2) |-> (tok_count == FULL));

  p_grant_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    (loc_busy && tok_count == FULL) |=> (loc_grant && !loc_busy));

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !loc_busy |=> !(out_valid && out_kind != 2'd2));

  p_reissue_is_request_r8: assert property (@(posedge clk) disable iff (rst)
    out_reissue |-> (out_valid && out_kind != 2'd2));

endmodule

bind tok_coherence_ctrl tok_coherence_ctrl_chk #(
  .TOTAL_TOKENS(TOTAL_TOKENS),
  .TOK_W       (TOK_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_kind    (in_kind),
  .in_tokens  (in_tokens),
  .out_valid  (out_valid),
  .out_kind   (out_kind),
  .out_tokens (out_tokens),
  .out_reissue(out_reissue),
  .loc_busy   (loc_busy),
  .loc_grant  (loc_grant),
  .tok_count  (tok_count),
  .perm       (perm),
  .tok_err    (tok_err)
);

// File: tb/tok_coherence_ctrl_test.sv
module tok_coherence_ctrl_test;

  localparam int unsigned TOTAL  = 16;
  localparam int unsigned NODE_W = 2;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TOK_W  = 5;
  localparam int unsigned TMO    = 16;

  typedef struct packed {
    logic [1:0]        kind;
    logic [NODE_W-1:0] node;
    logic [TOK_W-1:0]  tokens;
    logic [DATA_W-1:0] data;
    logic              reissue;
  } msg_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              loc_valid = 1'b0, loc_write = 1'b0;
  logic [DATA_W-1:0] loc_wdata = '0;
  logic              loc_busy, loc_grant;
  logic [DATA_W-1:0] loc_rdata;
  logic              in_valid = 1'b0;
  logic [1:0]        in_kind = 2'd0;
  logic [NODE_W-1:0] in_node = '0;
  logic [TOK_W-1:0]  in_tokens = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid, out_reissue, tok_err;
  logic [1:0]        out_kind, perm;
  logic [NODE_W-1:0] out_node;
  logic [TOK_W-1:0]  out_tokens, tok_count;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  msg_t exp_q[$];

  always #5 clk = ~clk;

  tok_coherence_ctrl #(
    .TOTAL_TOKENS(TOTAL), .NODE_W(NODE_W), .DATA_W(DATA_W),
    .MY_ID(1), .HOME_ID(1), .TIMEOUT(TMO)
  ) uut (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_write(loc_write), .loc_wdata(loc_wdata),
    .loc_busy(loc_busy), .loc_grant(loc_grant), .loc_rdata(loc_rdata),
    .in_valid(in_valid), .in_kind(in_kind), .in_node(in_node),
    .in_tokens(in_tokens), .in_data(in_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_node(out_node),
    .out_tokens(out_tokens), .out_data(out_data), .out_reissue(out_reissue),
    .tok_count(tok_count), .perm(perm), .tok_err(tok_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic msg_t mk(input logic [1:0] k, input int n, input int t,
                              input logic [DATA_W-1:0] d, input bit r);
    msg_t m;
    m.kind = k; m.node = NODE_W'(n); m.tokens = TOK_W'(t); m.data = d; m.reissue = r;
    return m;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      msg_t got, e;
      got = '{out_kind, out_node, out_tokens, out_data, out_reissue};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R8 unexpected message", longint'(got), 0);
      end else begin
        e = exp_q.pop_front();
        chk(got == e, "R3/R5/R7/R8/R10 message", longint'(got), longint'(e));
      end
    end
  end

  task automatic send_in(input logic [1:0] k, input int n, input int t, input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_node = NODE_W'(n); in_tokens = TOK_W'(t); in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic loc_op(input bit w, input logic [DATA_W-1:0] d);
    @(negedge clk);
    loc_valid = 1'b1; loc_write = w; loc_wdata = d;
    @(negedge clk);
    loc_valid = 1'b0;
  endtask

  task automatic wait_grant(input string req);
    int n = 0;
    while (!loc_grant && n < 4 * TMO) begin
      @(negedge clk);
      n++;
    end
    chk(loc_grant, req, loc_grant, 1);
  endtask

  task automatic wait_out();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 4 * TMO);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int gap;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk(tok_count == 5'd16, "R1 count", tok_count, 16);
    chk(perm == 2'd2, "R1/R2 perm", perm, 2);
    chk(!out_valid && !tok_err, "R1 quiet", {out_valid, tok_err}, 0);

    // R2/R11 local hits with all tokens
    loc_op(1'b1, 32'hA5A5_0001);
    wait_grant("R2 write hit grant");
    loc_op(1'b0, '0);
    wait_grant("R2 read hit grant");
    chk(loc_rdata == 32'hA5A5_0001, "R11 read data", loc_rdata, 32'hA5A5_0001);

    // R3 read request at full
    exp_q.push_back(mk(2'd2, 2, 1, 32'hA5A5_0001, 0));
    send_in(2'd0, 2, 0, '0);
    chk(tok_count == 5'd15, "R3 keep 15", tok_count, 15);
    chk(perm == 2'd1, "R2 read-only", perm, 1);

    // R4 partial holder ignores read request
    send_in(2'd0, 3, 0, '0);
    chk(!out_valid, "R4 no reply", out_valid, 0);
    chk(tok_count == 5'd15, "R4 count kept", tok_count, 15);

    // R7/R8 write miss, retry spacing, then satisfied
    exp_q.push_back(mk(2'd1, 1, 0, '0, 0));
    loc_op(1'b1, 32'h0000_BEEF);
    wait_out();
    chk(out_valid && out_reissue == 1'b0, "R7 first request", out_reissue, 0);
    exp_q.push_back(mk(2'd1, 1, 0, '0, 1));
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!out_valid && gap < 4 * TMO);
    chk(gap == TMO, "R8 retry period", gap, TMO);
    send_in(2'd2, 2, 1, 32'h1234);
    wait_grant("R7 grant after tokens");
    chk(tok_count == 5'd16 && perm == 2'd2, "R9 add to full", tok_count, 16);
    repeat (2 * TMO) @(negedge clk);
    chk(exp_q.size() == 0, "R8 retry stops", exp_q.size(), 0);
    loc_op(1'b0, '0);
    wait_grant("R11 read after write");
    chk(loc_rdata == 32'h0000_BEEF, "R11 write stored", loc_rdata, 32'hBEEF);

    // R5 write request takes everything
    exp_q.push_back(mk(2'd2, 3, 16, 32'h0000_BEEF, 0));
    send_in(2'd1, 3, 0, '0);
    chk(tok_count == 5'd0 && perm == 2'd0, "R5 drop to zero", tok_count, 0);

    // R6 zero holder ignores requests
    send_in(2'd1, 2, 0, '0);
    chk(!out_valid, "R6 write ignored", out_valid, 0);
    send_in(2'd0, 2, 0, '0);
    chk(!out_valid, "R6 read ignored", out_valid, 0);

    // R7/R9 read miss filled by tokens
    exp_q.push_back(mk(2'd0, 1, 0, '0, 0));
    loc_op(1'b0, '0);
    @(negedge clk);
    send_in(2'd2, 2, 3, 32'h77);
    wait_grant("R7 read grant");
    chk(loc_rdata == 32'h77, "R9 data taken at zero", loc_rdata, 32'h77);
    chk(tok_count == 5'd3 && perm == 2'd1, "R9 count 3", tok_count, 3);

    // R9 overflow
    send_in(2'd2, 2, 14, 32'h99);
    chk(tok_err == 1'b1, "R9 error flag", tok_err, 1);
    chk(tok_count == 5'd3, "R9 count unchanged", tok_count, 3);
    loc_op(1'b0, '0);
    wait_grant("R9 read");
    chk(loc_rdata == 32'h77, "R9 data kept", loc_rdata, 32'h77);

    // R10 reply and retry in the same cycle
    exp_q.push_back(mk(2'd1, 1, 0, '0, 0));
    loc_op(1'b1, 32'hC0DE);
    wait_out();
    exp_q.push_back(mk(2'd2, 2, 3, 32'h77, 0));
    exp_q.push_back(mk(2'd1, 1, 0, '0, 1));
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd1; in_node = 2'd2; in_tokens = '0; in_data = '0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_kind == 2'd2, "R10 reply first", out_kind, 2);
    @(negedge clk);
    chk(out_valid && out_reissue, "R10 retry next", out_reissue, 1);
    chk(tok_count == 5'd0, "R5 gave 3", tok_count, 0);

    send_in(2'd2, 2, 16, 32'h55);
    wait_grant("R7 write grant");
    loc_op(1'b0, '0);
    wait_grant("R11 read");
    chk(loc_rdata == 32'hC0DE, "R11 final data", loc_rdata, 32'hC0DE);
    chk(tok_err == 1'b1, "R9 sticky", tok_err, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    summary();
  end

endmodule